// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This unit sits beside a processor's fetch and decode path and raises a debug interrupt just before a chosen instruction runs. It has two match channels. Each channel holds a 20-bit instruction address and an enable bit. Software writes both over a small register bus. For every instruction, the core presents the instruction's start address, a one-cycle start strobe and a two-bit class code. The class code tells the unit whether the instruction's operation code is one byte or two. When an enabled channel holds the same address as the instruction that is starting, the unit sends out a one-cycle request, the number of the winning channel and a program-counter value for the stack.

This request does not pass through the interrupt mask or the priority logic. The unit has no input for the global enable flag or the current priority level, so neither can hold the request back. The program-counter value is the match address plus a fixed offset: plus 1 for the one-byte short forms and plus 2 for every other class. This value is not the true return address, and the handler must correct the stacked value before it returns. A match can only happen at an instruction's first byte, because the compare is made only on start strobes.

The instruction-side inputs carry no ready signal. The core cannot be stalled by this unit, so it has no back-pressure to honour. The start strobe acts as the valid qualifier, and the address and class are sampled only in a cycle where it is high. Outputs appear one clock after the strobe.

Top module: `amb_unit`

## Requirements
- R1: An active-high synchronous reset clears both channel addresses and both enable bits, so every register reads back as 0 and no request is raised after reset.
- R2: Register offsets are 0 (channel 0 address bits 15:0), 1 (channel 0 address bits 19:16 in data bits 3:0), 2 (channel 1 low part) and 3 (channel 1 high part). In a high-part read, data bits 15:4 always read 0, whatever value was written.
- R3: At register offset 4, bit 0 enables channel 0 and bit 1 enables channel 1. Both bits read back as written, and the other bits read 0.
- R4: When `insn_start` is high and `insn_addr` equals an enabled channel's address, `irq_req` is high for exactly the next cycle. It stays low in the following cycle unless another matching strobe arrives.
- R5: No request is raised when no strobe is present, when the address differs, or when the matching channel is disabled.
- R6: For class code 0 (two-byte operation code), `irq_pc` equals the match address plus 2.
- R7: For class code 1 (one-byte short form), `irq_pc` equals the match address plus 1.
- R8: For class codes 2 and 3 (all other instructions), `irq_pc` equals the match address plus 2.
- R9: `irq_src` gives the number of the matching channel. When both channels match the same instruction, channel 0 wins and `irq_src` is 0.
- R10: The program-counter sum wraps modulo 2^20. For example, a match at 0xFFFFF with class 0 gives 0x00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the offset on `reg_addr` (combinational) |
| insn_start | input | 1 | Marks the first cycle of an instruction |
| insn_addr | input | 20 | Start address of that instruction |
| insn_cls | input | 2 | Class code: 0 two-byte opcode, 1 one-byte short form, 2/3 other |
| irq_req | output | 1 | One-cycle address-match interrupt request |
| irq_src | output | 1 | Number of the winning channel |
| irq_pc | output | 20 | Program-counter value to stack |

## Verification
A corrupted channel address or enable bit has two visible effects, both within one cycle of the next strobe. The register readback shows the wrong value at once. A strobe at the programmed address then gives either no request or a request at the wrong address. If the offset selection or the arbitration is wrong, the `irq_pc` or `irq_src` value in the same cycle as the request is wrong. The bench therefore checks the request, source and stacked value in the cycle after every strobe. It also checks the readback after every register change.

// File: rtl/amb_pkg.sv
package amb_pkg;
  // Instruction class codes presented with each start strobe
  typedef enum logic [1:0] {
    CLS_OP2   = 2'd0,
    CLS_OP1   = 2'd1,
    CLS_OTH_A = 2'd2,
    CLS_OTH_B = 2'd3
  } insn_cls_e;

  localparam int unsigned OFS_ONE = 1;
  localparam int unsigned OFS_TWO = 2;
endpackage

// File: rtl/amb_chan.sv
module amb_chan #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          en_d,
  input  logic [AW-1:0] insn_addr,
  output logic [AW-1:0] addr_q,
  output logic          en_q,
  output logic          hit
);
  localparam int HW = AW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_lo) addr_q[DW-1:0]  <= wdata;
      if (wr_hi) addr_q[AW-1:DW] <= wdata[HW-1:0];
      if (wr_en) en_q            <= en_d;
    end
  end

  assign hit = en_q && (insn_addr == addr_q);
endmodule

// File: rtl/amb_arb.sv
module amb_arb
  import amb_pkg::*;
#(
  parameter int AW  = 20,
  parameter int NCH = 2,
  parameter int SW  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NCH-1:0] match_vec,
  input  logic [AW-1:0]  insn_addr,
  input  logic [1:0]     insn_cls,
  output logic           irq_req,
  output logic [SW-1:0]  irq_src,
  output logic [AW-1:0]  irq_pc
);
  logic [SW-1:0] sel;
  logic [AW-1:0] ofs;
  logic          take;

  // lowest channel number has priority
  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (match_vec[i]) sel = SW'(i);
    end
  end

  always_comb begin
    if (insn_cls_e'(insn_cls) == CLS_OP1) ofs = AW'(OFS_ONE);
    else                                  ofs = AW'(OFS_TWO);
  end

  assign take = start && (|match_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_src <= '0;
      irq_pc  <= '0;
    end else begin
      irq_req <= take;
      if (take) begin
        irq_src <= sel;
        irq_pc  <= insn_addr + ofs;
      end
    end
  end
endmodule

// File: rtl/amb_unit.sv
module amb_unit #(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int NCH = 2,
  parameter int RAW = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  reg_wr,
  input  logic [RAW-1:0]                        reg_addr,
  input  logic [DW-1:0]                         reg_wdata,
  output logic [DW-1:0]                         reg_rdata,
  input  logic                                  insn_start,
  input  logic [AW-1:0]                         insn_addr,
  input  logic [1:0]                            insn_cls,
  output logic                                  irq_req,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] irq_src,
  output logic [AW-1:0]                         irq_pc
);
  localparam int SW     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int HW     = AW - DW;
  localparam int EN_OFS = 2 * NCH;

  logic [AW-1:0]  ch_addr [NCH];
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] match_vec;
  logic           wr_enreg;

  assign wr_enreg = reg_wr && (reg_addr == RAW'(EN_OFS));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    amb_chan #(.AW(AW), .DW(DW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_lo     (reg_wr && (reg_addr == RAW'(2 * c))),
      .wr_hi     (reg_wr && (reg_addr == RAW'(2 * c + 1))),
      .wr_en     (wr_enreg),
      .wdata     (reg_wdata),
      .en_d      (reg_wdata[c]),
      .insn_addr (insn_addr),
      .addr_q    (ch_addr[c]),
      .en_q      (ch_en[c]),
      .hit       (match_vec[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == RAW'(2 * c))     reg_rdata = ch_addr[c][DW-1:0];
      if (reg_addr == RAW'(2 * c + 1)) reg_rdata = DW'(ch_addr[c][AW-1:DW]);
    end
    if (reg_addr == RAW'(EN_OFS)) reg_rdata = DW'(ch_en);
  end

  amb_arb #(.AW(AW), .NCH(NCH), .SW(SW)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .start     (insn_start),
    .match_vec (match_vec),
    .insn_addr (insn_addr),
    .insn_cls  (insn_cls),
    .irq_req   (irq_req),
    .irq_src   (irq_src),
    .irq_pc    (irq_pc)
  );
endmodule

// File: rtl/amb_unit_chk.sv
module amb_unit_chk #(
  parameter int AW  = 20,
  parameter int NCH = 2,
  parameter int SW  = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           insn_start,
  input logic [AW-1:0]  insn_addr,
  input logic [1:0]     insn_cls,
  input logic [NCH-1:0] match_vec,
  input logic           irq_req,
  input logic [SW-1:0]  irq_src,
  input logic [AW-1:0]  irq_pc
);
  p_req_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (insn_start && (|match_vec)) |=> irq_req);

  p_quiet_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !insn_start |=> !irq_req);

  p_quiet_no_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (match_vec == '0) |=> !irq_req);

  p_pc_two_r6: assert property (@(posedge clk) disable iff (rst)
    (insn_start && (|match_vec) && insn_cls == 2'd0) |=> (irq_pc == $past(insn_addr) + AW'(2)));

  p_pc_one_r7: assert property (@(posedge clk) disable iff (rst)
    (insn_start && (|match_vec) && insn_cls == 2'd1) |=> (irq_pc == $past(insn_addr) + AW'(1)));

  p_pc_other_r8: assert property (@(posedge clk) disable iff (rst)
    (insn_start && (|match_vec) && insn_cls[1]) |=> (irq_pc == $past(insn_addr) + AW'(2)));

  p_ch0_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (insn_start && match_vec[0]) |=> (irq_src == '0));
endmodule

bind amb_unit amb_unit_chk #(.AW(AW), .NCH(NCH), .SW(SW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .insn_start (insn_start),
  .insn_addr  (insn_addr),
  .insn_cls   (insn_cls),
  .match_vec  (match_vec),
  .irq_req    (irq_req),
  .irq_src    (irq_src),
  .irq_pc     (irq_pc)
);

// File: tb/amb_unit_test.sv
module amb_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        insn_start;
  logic [19:0] insn_addr;
  logic [1:0]  insn_cls;
  logic        irq_req;
  logic [0:0]  irq_src;
  logic [19:0] irq_pc;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  amb_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insn_start(insn_start),
    .insn_addr(insn_addr), .insn_cls(insn_cls), .irq_req(irq_req),
    .irq_src(irq_src), .irq_pc(irq_pc)
  );

  // {start, addr, cls, exp_req, exp_src, exp_pc}
  localparam int VN = 8;
  localparam logic [44:0] VEC [VN] = '{
    {1'b1, 20'h12345, 2'd0, 1'b1, 1'b0, 20'h12347},   // R6
    {1'b1, 20'h12345, 2'd1, 1'b1, 1'b0, 20'h12346},   // R7
    {1'b1, 20'h0ABCD, 2'd2, 1'b1, 1'b1, 20'h0ABCF},   // R8
    {1'b1, 20'h0ABCD, 2'd3, 1'b1, 1'b1, 20'h0ABCF},   // R8
    {1'b1, 20'h12344, 2'd0, 1'b0, 1'b0, 20'h00000},   // R5
    {1'b0, 20'h12345, 2'd0, 1'b0, 1'b0, 20'h00000},   // R5
    {1'b1, 20'h0ABCD, 2'd1, 1'b1, 1'b1, 20'h0ABCE},   // R7
    {1'b1, 20'h02345, 2'd0, 1'b0, 1'b0, 20'h00000}    // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  // apply one instruction for a cycle, then sample in the cycle after
  task automatic issue(input logic s, input logic [19:0] a, input logic [1:0] c);
    insn_start = s; insn_addr = a; insn_cls = c;
    @(posedge clk); @(negedge clk);
    insn_start = 1'b0;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    insn_start = 1'b0; insn_addr = '0; insn_cls = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_check("R1", 3'(a), 16'h0000);
    check("R1 req", 32'(irq_req), 32'd0);

    // R2 program addresses, high bits above 3 read zero
    wr(3'd0, 16'h2345); wr(3'd1, 16'hFFF1);
    wr(3'd2, 16'hABCD); wr(3'd3, 16'h0000);
    rd_check("R2 lo0", 3'd0, 16'h2345);
    rd_check("R2 hi0", 3'd1, 16'h0001);
    rd_check("R2 lo1", 3'd2, 16'hABCD);
    rd_check("R2 hi1", 3'd3, 16'h0000);

    // R5 disabled channels give nothing
    issue(1'b1, 20'h12345, 2'd0);
    check("R5 disabled", 32'(irq_req), 32'd0);

    // R3 enable register
    wr(3'd4, 16'hFFFF);
    rd_check("R3 en", 3'd4, 16'h0003);

    // vector table
    for (int i = 0; i < VN; i++) begin
      issue(VEC[i][44], VEC[i][43:24], VEC[i][23:22]);
      check("R4 req", 32'(irq_req), 32'(VEC[i][21]));
      if (VEC[i][21]) begin
        check("R9 src", 32'(irq_src), 32'(VEC[i][20]));
        check("R6/R7/R8 pc", 32'(irq_pc), 32'(VEC[i][19:0]));
      end
    end

    // R4 single pulse: strobe then idle
    issue(1'b1, 20'h12345, 2'd0);
    check("R4 pulse", 32'(irq_req), 32'd1);
    @(posedge clk); @(negedge clk);
    check("R4 drop", 32'(irq_req), 32'd0);

    // R5 disable channel 0 only
    wr(3'd4, 16'h0002);
    rd_check("R3 en1", 3'd4, 16'h0002);
    issue(1'b1, 20'h12345, 2'd0);
    check("R5 ch0 off", 32'(irq_req), 32'd0);
    issue(1'b1, 20'h0ABCD, 2'd0);
    check("R5 ch1 on", 32'(irq_req), 32'd1);

    // R9 both channels on the same address
    wr(3'd2, 16'h2345); wr(3'd3, 16'h0001); wr(3'd4, 16'h0003);
    issue(1'b1, 20'h12345, 2'd1);
    check("R9 both req", 32'(irq_req), 32'd1);
    check("R9 both src", 32'(irq_src), 32'd0);
    check("R9 both pc", 32'(irq_pc), 32'h12346);

    // R10 wrap
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'h000F);
    issue(1'b1, 20'hFFFFF, 2'd0);
    check("R10 req", 32'(irq_req), 32'd1);
    check("R10 pc", 32'(irq_pc), 32'h00001);
    issue(1'b1, 20'hFFFFF, 2'd1);
    check("R10 pc1", 32'(irq_pc), 32'h00000);

    // R1 reset mid-run clears everything
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    rd_check("R1 en", 3'd4, 16'h0000);
    rd_check("R1 hi0", 3'd1, 16'h0000);
    issue(1'b1, 20'h00000, 2'd0);
    check("R1 no req", 32'(irq_req), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule